// File: doc/BRIEF.md
# Dual-Cap Burst Splitter

This block takes one long transfer on an external memory port and cuts it into a series of bus bursts. Each burst is no longer than two independent caps. The requester cap limits how long one requester can hold the bus, and so bounds the wait seen by the others. The bank cap limits how long chip-select stays low on one device, so that the device can still refresh itself. Both caps are read from configuration tables: one 16-bit entry per requester and one per bank. An entry of zero means that cap is not applied.

A request gives a start address, a byte count, a bank, a requester id, a half-rate flag and a write flag. The bank cap is set in full-rate terms. In half-rate mode it is halved, so that it still stands for the same time on the bus. The requester cap does not change with the rate. A requester marked as priority keeps the bus from one fragment to the next: every fragment except its last is issued with a hold flag. A write to a bank marked as flash is never split. If it is longer than the flash write maximum, the request is rejected.

The controller is a four-state machine:
- `ST_IDLE` accepts a request and moves to `ST_SIZE`, or moves to `ST_REJECT` for a request that is not allowed.
- `ST_SIZE` computes the next fragment length and moves to `ST_SEND`.
- `ST_SEND` offers the fragment on a valid/ready handshake. When the fragment is taken, it returns to `ST_IDLE` if that was the last fragment. Otherwise it advances the address and the remaining count and goes back to `ST_SIZE`.
- `ST_REJECT` pulses the reject output for one cycle and returns to `ST_IDLE`.

Top module: `burst_splitter`

## Requirements
- R1: Each burst length equals the smallest of the remaining byte count, the requester cap and the bank cap. A table entry of 0 means that cap is unlimited.
- R2: The first burst starts at the request address. Each following burst starts at the previous burst address plus the previous burst length. The burst lengths add up to the request byte count.
- R3: When `req_half` is 1, the bank cap is the table entry shifted right by one bit, with a minimum of 1 for a nonzero entry. The requester cap is used unchanged at either rate.
- R4: `burst_last` is 1 on the final burst of a transfer and 0 on every other burst.
- R5: For a requester whose bit in `cfg_req_prio` is 1, `burst_hold` is 1 on every non-final burst. `burst_hold` is 0 on final bursts and for requesters that are not priority. `req_ready` is 0 while a transfer is in progress.
- R6: A write (`req_write`=1) to a bank whose `cfg_bank_flash` bit is 1, with a count of at most FLASH_MAX (512), is issued as one burst and ignores both caps.
- R7: A request is rejected in either of two cases: it is a flash write longer than FLASH_MAX, or its count is 0. A rejected request gives a one-cycle `req_reject` pulse and no burst.
- R8: While `burst_valid` is 1 and `burst_ready` is 0, the burst outputs hold their values. No fragment is lost or repeated when the receiver stalls.
- R9: After reset, `req_ready` is 1, and `burst_valid` and `req_reject` are 0.
- R10: Every burst carries the bank and requester id of its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req_limit | input | NUM_REQ*16 | Per-requester cap table, entry i at bits [16*i +: 16] |
| cfg_bank_limit | input | NUM_BANK*16 | Per-bank full-rate cap table, entry i at bits [16*i +: 16] |
| cfg_bank_flash | input | NUM_BANK | Bit i set: bank i is flash |
| cfg_req_prio | input | NUM_REQ | Bit i set: requester i is priority |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_bank | input | clog2(NUM_BANK) | Target bank |
| req_id | input | clog2(NUM_REQ) | Requester id |
| req_half | input | 1 | Half-rate data transfer |
| req_write | input | 1 | Transfer is a write |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| burst_valid | output | 1 | Burst command offered |
| burst_ready | input | 1 | Burst command taken |
| burst_addr | output | ADDR_W | Burst start address |
| burst_len | output | LEN_W | Burst byte count |
| burst_bank | output | clog2(NUM_BANK) | Bank of the burst |
| burst_id | output | clog2(NUM_REQ) | Requester of the burst |
| burst_last | output | 1 | Final burst of the transfer |
| burst_hold | output | 1 | Keep the bus after this burst |

## Verification
The splitting is driven with patterns chosen so that each one has a different cap binding the length:
- the requester cap alone;
- the bank cap alone;
- the halved bank cap, against requester caps just above and just below it, which shows that only the bank cap scales with the rate;
- a bank entry of 1 at half rate;
- both caps zero, which gives a single burst beyond 16 bits;
- the 65535 maximum.

Flash writes at exactly 512 bytes and at 513 bytes, and a flash read of the same size, separate the unsplit, rejected and normally split paths. A run with a stalling receiver shows that the fragment sequence does not depend on backpressure. A priority requester is compared against a normal one through the hold flag.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SIZE,
        ST_SEND,
        ST_REJECT
    } split_state_t;
endpackage

// File: rtl/cap_lookup.sv
module cap_lookup #(
    parameter int NUM_REQ  = 4,
    parameter int NUM_BANK = 4,
    parameter int LIM_W    = 16,
    parameter int LEN_W    = 32,
    localparam int ID_W    = $clog2(NUM_REQ),
    localparam int BANK_W  = $clog2(NUM_BANK)
) (
    input  logic [NUM_REQ*LIM_W-1:0]  req_tbl,
    input  logic [NUM_BANK*LIM_W-1:0] bank_tbl,
    input  logic [ID_W-1:0]           id,
    input  logic [BANK_W-1:0]         bank,
    input  logic                      half,
    output logic [LEN_W-1:0]          req_cap,
    output logic [LEN_W-1:0]          bank_cap
);
    logic [LIM_W-1:0] req_arr  [NUM_REQ];
    logic [LIM_W-1:0] bank_arr [NUM_BANK];

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        assign req_arr[g] = req_tbl[g*LIM_W +: LIM_W];
    end
    for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
        assign bank_arr[g] = bank_tbl[g*LIM_W +: LIM_W];
    end

    logic [LIM_W-1:0] req_raw, bank_raw, bank_scaled;

    always_comb begin
        req_raw  = req_arr[id];
        bank_raw = bank_arr[bank];
        // Half rate: half the bytes in the same time window, never below 1
        if (half) begin
            bank_scaled = bank_raw >> 1;
            if (bank_raw == LIM_W'(1)) bank_scaled = LIM_W'(1);
        end else begin
            bank_scaled = bank_raw;
        end
        req_cap  = (req_raw == '0)     ? '1 : LEN_W'(req_raw);
        bank_cap = (bank_scaled == '0) ? '1 : LEN_W'(bank_scaled);
    end
endmodule

// File: rtl/len_min.sv
module len_min #(
    parameter int LEN_W = 32
) (
    input  logic [LEN_W-1:0] remaining,
    input  logic [LEN_W-1:0] cap_a,
    input  logic [LEN_W-1:0] cap_b,
    input  logic             uncapped,
    output logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] cap_min;

    always_comb begin
        cap_min = (cap_a < cap_b) ? cap_a : cap_b;
        if (uncapped || remaining <= cap_min) len = remaining;
        else                                  len = cap_min;
        last = (len == remaining);
    end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
    import splitter_pkg::*;
#(
    parameter int NUM_REQ   = 4,
    parameter int NUM_BANK  = 4,
    parameter int LIM_W     = 16,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 32,
    parameter int FLASH_MAX = 512,
    localparam int ID_W     = $clog2(NUM_REQ),
    localparam int BANK_W   = $clog2(NUM_BANK)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ*LIM_W-1:0]  cfg_req_limit,
    input  logic [NUM_BANK*LIM_W-1:0] cfg_bank_limit,
    input  logic [NUM_BANK-1:0]       cfg_bank_flash,
    input  logic [NUM_REQ-1:0]        cfg_req_prio,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [LEN_W-1:0]          req_len,
    input  logic [BANK_W-1:0]         req_bank,
    input  logic [ID_W-1:0]           req_id,
    input  logic                      req_half,
    input  logic                      req_write,
    output logic                      req_reject,
    output logic                      burst_valid,
    input  logic                      burst_ready,
    output logic [ADDR_W-1:0]         burst_addr,
    output logic [LEN_W-1:0]          burst_len,
    output logic [BANK_W-1:0]         burst_bank,
    output logic [ID_W-1:0]           burst_id,
    output logic                      burst_last,
    output logic                      burst_hold
);
    split_state_t st, st_nxt;

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  rem;
    logic [BANK_W-1:0] lat_bank;
    logic [ID_W-1:0]   lat_id;
    logic              lat_half, lat_flash, lat_prio;
    logic [LEN_W-1:0]  frag_len;
    logic              frag_last;

    logic [LEN_W-1:0]  cap_req, cap_bank, calc_len;
    logic              calc_last;
    logic              in_flash_wr, in_bad;

    cap_lookup #(
        .NUM_REQ (NUM_REQ),
        .NUM_BANK(NUM_BANK),
        .LIM_W   (LIM_W),
        .LEN_W   (LEN_W)
    ) i_caps (
        .req_tbl (cfg_req_limit),
        .bank_tbl(cfg_bank_limit),
        .id      (lat_id),
        .bank    (lat_bank),
        .half    (lat_half),
        .req_cap (cap_req),
        .bank_cap(cap_bank)
    );

    len_min #(.LEN_W(LEN_W)) i_min (
        .remaining(rem),
        .cap_a    (cap_req),
        .cap_b    (cap_bank),
        .uncapped (lat_flash),
        .len      (calc_len),
        .last     (calc_last)
    );

    always_comb begin
        in_flash_wr = req_write && cfg_bank_flash[req_bank];
        in_bad      = (req_len == '0) ||
                      (in_flash_wr && req_len > LEN_W'(FLASH_MAX));
    end

    // Next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (req_valid) st_nxt = in_bad ? ST_REJECT : ST_SIZE;
            ST_SIZE:   st_nxt = ST_SEND;
            ST_SEND:   if (burst_ready) st_nxt = frag_last ? ST_IDLE : ST_SIZE;
            ST_REJECT: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cur_addr  <= '0;
            rem       <= '0;
            lat_bank  <= '0;
            lat_id    <= '0;
            lat_half  <= 1'b0;
            lat_flash <= 1'b0;
            lat_prio  <= 1'b0;
            frag_len  <= '0;
            frag_last <= 1'b0;
        end else begin
            st <= st_nxt;
            unique case (st)
                ST_IDLE: if (req_valid && !in_bad) begin
                    cur_addr  <= req_addr;
                    rem       <= req_len;
                    lat_bank  <= req_bank;
                    lat_id    <= req_id;
                    lat_half  <= req_half;
                    lat_flash <= in_flash_wr;
                    lat_prio  <= cfg_req_prio[req_id];
                end
                ST_SIZE: begin
                    frag_len  <= calc_len;
                    frag_last <= calc_last;
                end
                ST_SEND: if (burst_ready && !frag_last) begin
                    cur_addr <= cur_addr + ADDR_W'(frag_len);
                    rem      <= rem - frag_len;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (st == ST_IDLE);
        req_reject  = (st == ST_REJECT);
        burst_valid = (st == ST_SEND);
        burst_addr  = cur_addr;
        burst_len   = frag_len;
        burst_bank  = lat_bank;
        burst_id    = lat_id;
        burst_last  = frag_last;
        burst_hold  = (st == ST_SEND) && lat_prio && !frag_last;
    end
endmodule

// File: rtl/split_chk.sv
module split_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_reject,
    input logic              burst_valid,
    input logic              burst_ready,
    input logic [ADDR_W-1:0] burst_addr,
    input logic [LEN_W-1:0]  burst_len,
    input logic              burst_last,
    input logic              burst_hold
);
    logic              pend;
    logic [ADDR_W-1:0] nxt_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            nxt_addr <= '0;
        end else if (burst_valid && burst_ready) begin
            pend     <= !burst_last;
            nxt_addr <= burst_addr + ADDR_W'(burst_len);
        end
    end

    // R2
    addr_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && pend) |-> (burst_addr == nxt_addr));

    // R1
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (burst_len != '0));

    // R5
    hold_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_hold |-> (burst_valid && !burst_last));

    // R5
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> !req_ready);

    // R7
    reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |=> !req_reject);

    // R7
    reject_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> !burst_valid);

    // R8
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !burst_ready) |=>
            (burst_valid && $stable(burst_addr) && $stable(burst_len) && $stable(burst_last)));
endmodule

bind burst_splitter split_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_split_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .req_reject (req_reject),
    .burst_valid(burst_valid),
    .burst_ready(burst_ready),
    .burst_addr (burst_addr),
    .burst_len  (burst_len),
    .burst_last (burst_last),
    .burst_hold (burst_hold)
);

// File: tb/test_burst_splitter.sv
module test_burst_splitter;
    localparam int CLK_P = 10;
    localparam int NR = 4, NB = 4, LW = 16, AW = 32, BW = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [NR*LW-1:0] cfg_req_limit;
    logic [NB*LW-1:0] cfg_bank_limit;
    logic [NB-1:0]    cfg_bank_flash;
    logic [NR-1:0]    cfg_req_prio;
    logic req_valid = 1'b0, req_half = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_len = '0;
    logic [1:0] req_bank = '0, req_id = '0;
    logic req_ready, req_reject, burst_valid, burst_last, burst_hold;
    logic burst_ready = 1'b1;
    logic [AW-1:0] burst_addr;
    logic [BW-1:0] burst_len;
    logic [1:0] burst_bank, burst_id;

    burst_splitter i_burst_splitter (
        .clk(clk), .rst_n(rst_n),
        .cfg_req_limit(cfg_req_limit), .cfg_bank_limit(cfg_bank_limit),
        .cfg_bank_flash(cfg_bank_flash), .cfg_req_prio(cfg_req_prio),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_bank(req_bank), .req_id(req_id),
        .req_half(req_half), .req_write(req_write), .req_reject(req_reject),
        .burst_valid(burst_valid), .burst_ready(burst_ready),
        .burst_addr(burst_addr), .burst_len(burst_len), .burst_bank(burst_bank),
        .burst_id(burst_id), .burst_last(burst_last), .burst_hold(burst_hold)
    );

    int total = 0, bad = 0;

    // Fragment collector
    int nfrag = 0, nrej = 0;
    logic [AW-1:0] f_addr [16];
    logic [BW-1:0] f_len  [16];
    logic f_last [16], f_hold [16];
    logic [1:0] f_bank [16], f_id [16];

    always @(negedge clk) begin
        if (rst_n && burst_valid && burst_ready) begin
            if (nfrag < 16) begin
                f_addr[nfrag] = burst_addr; f_len[nfrag] = burst_len;
                f_last[nfrag] = burst_last; f_hold[nfrag] = burst_hold;
                f_bank[nfrag] = burst_bank; f_id[nfrag] = burst_id;
            end
            nfrag++;
        end
        if (rst_n && req_reject) nrej++;
    end

    // Receiver stall pattern
    bit stall_en = 0;
    int cyc = 0;
    initial forever begin
        @(posedge clk);
        #1;
        cyc++;
        burst_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic [BW-1:0] n,
                         input logic [1:0] b, input logic [1:0] id,
                         input logic h, input logic w);
        nfrag = 0; nrej = 0;
        @(negedge clk);
        req_addr = a; req_len = n; req_bank = b; req_id = id;
        req_half = h; req_write = w; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (req_ready) break;
            @(negedge clk);
        end
    endtask

    // Run one transfer; expect fragments of cap bytes each (last one remainder)
    task automatic split_case(input string req, input logic [AW-1:0] a,
                              input logic [BW-1:0] n, input logic [1:0] b,
                              input logic [1:0] id, input logic h,
                              input logic w, input longint cap, input bit prio);
        longint rem = n, ea = a;
        int exp_n = 0;
        issue(a, n, b, id, h, w);
        while (rem > 0) begin
            longint l = (rem < cap) ? rem : cap;
            bit lst = (l == rem);
            if (exp_n < 16 && exp_n < nfrag) begin
                chk(f_len[exp_n] == BW'(l), req, "len", f_len[exp_n], l);
                chk(f_addr[exp_n] == AW'(ea), "R2", "addr", f_addr[exp_n], ea);
                chk(f_last[exp_n] == lst, "R4", "last", f_last[exp_n], lst);
                chk(f_hold[exp_n] == (prio && !lst), "R5", "hold",
                    f_hold[exp_n], prio && !lst);
                chk(f_bank[exp_n] == b && f_id[exp_n] == id, "R10", "bank/id",
                    {f_bank[exp_n], f_id[exp_n]}, {b, id});
            end
            rem -= l; ea += l; exp_n++;
        end
        chk(nfrag == exp_n, req, "fragment count", nfrag, exp_n);
        chk(nrej == 0, "R7", "no reject", nrej, 0);
    endtask

    task automatic reject_case(input logic [BW-1:0] n, input logic [1:0] b,
                               input logic w);
        issue(32'h100, n, b, 2'd0, 1'b0, w);
        repeat (2) @(negedge clk);
        chk(nrej == 1, "R7", "reject pulses", nrej, 1);
        chk(nfrag == 0, "R7", "bursts after reject", nfrag, 0);
    endtask

    initial begin
        // requester caps: id0=300 id1=none id2=150(prio) id3=65535
        cfg_req_limit  = {16'd65535, 16'd150, 16'd0, 16'd300};
        // bank caps: b0=none b1=400 b2=1 b3=100 (flash)
        cfg_bank_limit = {16'd100, 16'd1, 16'd400, 16'd0};
        cfg_bank_flash = 4'b1000;
        cfg_req_prio   = 4'b0100;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(req_ready == 1'b1, "R9", "req_ready", req_ready, 1);
        chk(burst_valid == 1'b0, "R9", "burst_valid", burst_valid, 0);
        chk(req_reject == 1'b0, "R9", "req_reject", req_reject, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        split_case("R1", 32'h1000, 1000, 2'd0, 2'd0, 0, 0, 300, 0);  // requester cap
        split_case("R1", 32'h2000, 1000, 2'd1, 2'd1, 0, 0, 400, 0);  // bank cap
        split_case("R3", 32'h3000, 500, 2'd1, 2'd1, 1, 0, 200, 0);   // halved bank
        split_case("R3", 32'h3100, 500, 2'd1, 2'd0, 1, 0, 200, 0);   // 300 vs 200
        split_case("R3", 32'h3200, 500, 2'd1, 2'd2, 1, 0, 150, 1);   // req not halved, prio R5
        split_case("R5", 32'h3300, 400, 2'd0, 2'd2, 0, 0, 150, 1);   // prio full rate
        split_case("R3", 32'h3400, 3, 2'd2, 2'd1, 1, 0, 1, 0);       // entry 1 at half rate
        split_case("R1", 32'h4000, 70000, 2'd0, 2'd1, 0, 0, 70000, 0); // no caps
        split_case("R1", 32'h5000, 65545, 2'd0, 2'd3, 0, 0, 65535, 0); // 16-bit max
        split_case("R6", 32'h6000, 512, 2'd3, 2'd0, 0, 1, 512, 0);   // flash write unsplit
        split_case("R6", 32'h6400, 512, 2'd3, 2'd0, 0, 0, 100, 0);   // flash read split
        reject_case(513, 2'd3, 1'b1);                                 // R7 too long
        reject_case(0, 2'd0, 1'b0);                                   // R7 zero count
        stall_en = 1;
        split_case("R8", 32'h7000, 1000, 2'd0, 2'd0, 0, 0, 300, 0);  // stalled receiver
        stall_en = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule